// File: doc/BRIEF.md
# Status Byte and Operand Width Unit

This unit keeps the processor status byte, a hidden emulation bit, the two accumulator halves, both index registers and the stack pointer of a CPU core. The core is a 16-bit extension of an 8-bit accumulator machine. Each clock the unit accepts one request on `op_i`. A request either edits the status byte under an 8-bit mask, swaps the emulation bit with the carry bit, or loads one register from `wdata_i`.

Two status bits set the operand widths at run time. Bit 5 selects 8-bit accumulator/memory operations when it is 1. Bit 4 selects 8-bit index operations when it is 1. The unit reports both widths to the datapath and applies them to its own registers. It truncates loads, preserves the high accumulator half and clears the index upper bytes. While the emulation bit is 1, the unit keeps legacy behaviour: both width bits read as 1 and the stack sits in page 0x01. Reset enters emulation. Swapping a 0 into the emulation bit enters native mode.

Top module: `status_width_unit`

## Requirements
- R1: After reset: emulation bit 1, status 0x30, C = 0x0000, X = Y = 0x0000, S = 0x01FF, and both width outputs low (8-bit).
- R2: Request code 1 clears every status bit whose mask bit is 1 and leaves the others unchanged. While emulation is 1, bits 5 and 4 stay 1.
- R3: Request code 2 sets every status bit whose mask bit is 1 and leaves the others unchanged.
- R4: Request code 3 exchanges the emulation bit with status bit 0 (carry). Both values appear on the next cycle.
- R5: `acc_wide_o` is the inverse of status bit 5 and `idx_wide_o` is the inverse of status bit 4. Both are 0 while emulation is 1.
- R6: Whenever status bit 4 is 1, the upper bytes of X and Y are zero. They become zero on the same edge on which the bit becomes 1.
- R7: Request code 4 with 8-bit accumulator width loads only the low half A from `wdata_i[7:0]`. The high half B keeps its value.
- R8: Request code 4 with 16-bit accumulator width loads all of C = {B, A} from `wdata_i`.
- R9: Request code 5 loads B from `wdata_i[7:0]` at either width, and A keeps its value.
- R10: Request codes 6 (X) and 7 (Y) load `wdata_i` at 16-bit index width. At 8-bit index width they load `{8'h00, wdata_i[7:0]}`.
- R11: Request code 8 loads S from `wdata_i` in native mode. While emulation is 1, the upper byte of S is always 0x01 and a load writes only the low byte.
- R12: An exchange that sets emulation to 1 forces status bits 5 and 4 to 1, clears the X/Y upper bytes and sets the S upper byte to 0x01 on the same edge. Code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Request code: 0 idle, 1 clear, 2 set, 3 exchange, 4 load C/A, 5 load B, 6 load X, 7 load Y, 8 load S |
| mask_i | input | 8 | Status bit mask for codes 1 and 2 |
| wdata_i | input | 16 | Load data for codes 4 to 8 |
| status_o | output | 8 | Visible status byte |
| emu_o | output | 1 | Hidden emulation bit |
| acc_wide_o | output | 1 | 1 when accumulator/memory operations are 16 bits |
| idx_wide_o | output | 1 | 1 when index operations are 16 bits |
| acc_o | output | 16 | Accumulator C = {B, A} |
| x_o | output | 16 | Index X |
| y_o | output | 16 | Index Y |
| sp_o | output | 16 | Stack pointer |

## Verification
The assertions assume that `op_i` carries one of the nine defined codes each cycle. They also assume that the inputs are stable around the rising edge. Unused codes 9 to 15 act as idle, and the properties depend on no value of them. The stimulus drives only legal codes and changes inputs on the falling edge. It walks through emulation entry and exit and every width combination. It then issues several hundred random requests against the behavioural model.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,
    OP_CLR  = 4'd1,
    OP_SET  = 4'd2,
    OP_SWAP = 4'd3,
    OP_LDC  = 4'd4,
    OP_LDB  = 4'd5,
    OP_LDX  = 4'd6,
    OP_LDY  = 4'd7,
    OP_LDS  = 4'd8
  } op_e;

  localparam int CARRY_BIT = 0;
  localparam int IDX_BIT   = 4;
  localparam int ACC_BIT   = 5;
endpackage

// File: rtl/psw_status.sv
module psw_status
  import psw_pkg::*;
#(
  parameter int         ST_W  = 8,
  parameter logic [7:0] P_RST = 8'h30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  op_e             op_i,
  input  logic [ST_W-1:0] mask_i,
  output logic [ST_W-1:0] p_q_o,
  output logic            e_q_o,
  output logic [ST_W-1:0] p_d_o,
  output logic            e_d_o
);
  localparam logic [ST_W-1:0] FORCE_M = ST_W'((1 << ACC_BIT) | (1 << IDX_BIT));

  logic [ST_W-1:0] p_q, p_d;
  logic            e_q, e_d;

  always_comb begin
    p_d = p_q;
    e_d = e_q;
    unique case (op_i)
      OP_CLR:  p_d = p_q & ~mask_i;
      OP_SET:  p_d = p_q | mask_i;
      OP_SWAP: begin
        e_d            = p_q[CARRY_BIT];
        p_d[CARRY_BIT] = e_q;
      end
      default: ;
    endcase
    // legacy mode pins both widths to 8 bits
    if (e_d) p_d = p_d | FORCE_M;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= P_RST[ST_W-1:0];
      e_q <= 1'b1;
    end else begin
      p_q <= p_d;
      e_q <= e_d;
    end
  end

  assign p_q_o = p_q;
  assign e_q_o = e_q;
  assign p_d_o = p_d;
  assign e_d_o = e_d;
endmodule

// File: rtl/psw_acc.sv
module psw_acc #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_c_i,
  input  logic              wr_b_i,
  input  logic              narrow_i,
  input  logic [2*HALF_W-1:0] data_i,
  output logic [2*HALF_W-1:0] c_o
);
  logic [HALF_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (wr_c_i) begin
      a_q <= data_i[HALF_W-1:0];
      if (!narrow_i) b_q <= data_i[2*HALF_W-1:HALF_W];
    end else if (wr_b_i) begin
      b_q <= data_i[HALF_W-1:0];
    end
  end

  assign c_o = {b_q, a_q};
endmodule

// File: rtl/psw_idx.sv
module psw_idx #(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic                narrow_i,
  input  logic                clr_hi_i,
  input  logic [2*HALF_W-1:0] data_i,
  output logic [2*HALF_W-1:0] q_o
);
  logic [2*HALF_W-1:0] q, d;

  always_comb begin
    d = q;
    if (ld_i) d = narrow_i ? {{HALF_W{1'b0}}, data_i[HALF_W-1:0]} : data_i;
    if (clr_hi_i) d[2*HALF_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/psw_stack.sv
module psw_stack #(
  parameter int              HALF_W = 8,
  parameter logic [HALF_W-1:0] PAGE = 8'h01,
  parameter logic [HALF_W-1:0] LOW_RST = 8'hFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic                emu_q_i,
  input  logic                emu_d_i,
  input  logic [2*HALF_W-1:0] data_i,
  output logic [2*HALF_W-1:0] q_o
);
  logic [2*HALF_W-1:0] q, d;

  always_comb begin
    d = q;
    if (ld_i) d = emu_q_i ? {PAGE, data_i[HALF_W-1:0]} : data_i;
    if (emu_d_i) d[2*HALF_W-1:HALF_W] = PAGE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {PAGE, LOW_RST};
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/status_width_unit.sv
module status_width_unit
  import psw_pkg::*;
#(
  parameter int ST_W   = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [ST_W-1:0]   mask_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [ST_W-1:0]   status_o,
  output logic              emu_o,
  output logic              acc_wide_o,
  output logic              idx_wide_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] x_o,
  output logic [WORD_W-1:0] y_o,
  output logic [WORD_W-1:0] sp_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int N_IDX  = 2;

  op_e             op;
  logic [ST_W-1:0] p_q, p_d;
  logic            e_q, e_d;
  logic [WORD_W-1:0] idx_q [N_IDX];
  logic [N_IDX-1:0]  idx_ld;

  always_comb begin
    case (op_i)
      4'd1:    op = OP_CLR;
      4'd2:    op = OP_SET;
      4'd3:    op = OP_SWAP;
      4'd4:    op = OP_LDC;
      4'd5:    op = OP_LDB;
      4'd6:    op = OP_LDX;
      4'd7:    op = OP_LDY;
      4'd8:    op = OP_LDS;
      default: op = OP_IDLE;
    endcase
  end

  psw_status #(.ST_W(ST_W), .P_RST(8'h30)) i_status (
    .clk_i, .rst_ni, .op_i(op), .mask_i,
    .p_q_o(p_q), .e_q_o(e_q), .p_d_o(p_d), .e_d_o(e_d)
  );

  psw_acc #(.HALF_W(HALF_W)) i_acc (
    .clk_i, .rst_ni,
    .wr_c_i(op == OP_LDC), .wr_b_i(op == OP_LDB),
    .narrow_i(p_q[ACC_BIT]), .data_i(wdata_i), .c_o(acc_o)
  );

  assign idx_ld = {op == OP_LDY, op == OP_LDX};

  for (genvar g = 0; g < N_IDX; g++) begin : g_idx
    psw_idx #(.HALF_W(HALF_W)) i_idx (
      .clk_i, .rst_ni, .ld_i(idx_ld[g]),
      .narrow_i(p_q[IDX_BIT]), .clr_hi_i(p_d[IDX_BIT]),
      .data_i(wdata_i), .q_o(idx_q[g])
    );
  end

  psw_stack #(.HALF_W(HALF_W), .PAGE(HALF_W'(1)), .LOW_RST({HALF_W{1'b1}})) i_stack (
    .clk_i, .rst_ni, .ld_i(op == OP_LDS),
    .emu_q_i(e_q), .emu_d_i(e_d), .data_i(wdata_i), .q_o(sp_o)
  );

  assign x_o        = idx_q[0];
  assign y_o        = idx_q[1];
  assign status_o   = p_q;
  assign emu_o      = e_q;
  assign acc_wide_o = ~p_q[ACC_BIT];
  assign idx_wide_o = ~p_q[IDX_BIT];
endmodule

module status_width_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  op_i,
  input logic [7:0]  status_o,
  input logic        emu_o,
  input logic        acc_wide_o,
  input logic        idx_wide_o,
  input logic [15:0] acc_o,
  input logic [15:0] x_o,
  input logic [15:0] y_o,
  input logic [15:0] sp_o
);
  // R5
  emu_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emu_o |-> (!acc_wide_o && !idx_wide_o));
  // R6
  idx_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wide_o |-> (x_o[15:8] == 8'h00 && y_o[15:8] == 8'h00));
  // R11
  stack_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emu_o |-> (sp_o[15:8] == 8'h01));
  // R4
  swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3) |=> (emu_o == $past(status_o[0]) && status_o[0] == $past(emu_o)));
  // R7
  acc_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4 && !acc_wide_o) |=> $stable(acc_o[15:8]));
  // R2
  clr_emu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd1 && emu_o) |=> (status_o[5:4] == 2'b11));
endmodule

bind status_width_unit status_width_chk i_status_width_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .status_o(status_o),
  .emu_o(emu_o), .acc_wide_o(acc_wide_o), .idx_wide_o(idx_wide_o),
  .acc_o(acc_o), .x_o(x_o), .y_o(y_o), .sp_o(sp_o)
);

// File: tb/test_status_width_unit.sv
module test_status_width_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [7:0]  mask_i = 8'h00;
  logic [15:0] wdata_i = 16'h0000;
  logic [7:0]  status_o;
  logic        emu_o, acc_wide_o, idx_wide_o;
  logic [15:0] acc_o, x_o, y_o, sp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0]  pm;
  logic        em;
  logic [7:0]  am, bm;
  logic [15:0] xm, ym, sm;

  always #5 clk_i = ~clk_i;

  status_width_unit i_status_width_unit (.*);

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "status R2/R3", {8'h00, status_o}, {8'h00, pm});
    chk(tag, "emu R4", {15'd0, emu_o}, {15'd0, em});
    chk(tag, "acc_wide R5", {15'd0, acc_wide_o}, {15'd0, ~pm[5]});
    chk(tag, "idx_wide R5", {15'd0, idx_wide_o}, {15'd0, ~pm[4]});
    chk(tag, "acc R7/R8/R9", acc_o, {bm, am});
    chk(tag, "x R10/R6", x_o, xm);
    chk(tag, "y R10/R6", y_o, ym);
    chk(tag, "sp R11", sp_o, sm);
  endtask

  task automatic model(logic [3:0] op, logic [7:0] m, logic [15:0] d);
    logic t;
    case (op)
      4'd1: begin pm = pm & ~m; if (em) pm = pm | 8'h30; end
      4'd2: pm = pm | m;
      4'd3: begin t = em; em = pm[0]; pm[0] = t; if (em) pm = pm | 8'h30; end
      4'd4: if (pm[5]) am = d[7:0]; else {bm, am} = d;
      4'd5: bm = d[7:0];
      4'd6: xm = pm[4] ? {8'h00, d[7:0]} : d;
      4'd7: ym = pm[4] ? {8'h00, d[7:0]} : d;
      4'd8: sm = em ? {8'h01, d[7:0]} : d;
      default: ;
    endcase
    if (pm[4]) begin xm[15:8] = 8'h00; ym[15:8] = 8'h00; end
    if (em) sm[15:8] = 8'h01;
  endtask

  task automatic step(logic [3:0] op, logic [7:0] m, logic [15:0] d, string tag);
    op_i = op; mask_i = m; wdata_i = d;
    @(posedge clk_i);
    model(op, m, d);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  initial begin
    pm = 8'h30; em = 1'b1; am = 8'h00; bm = 8'h00;
    xm = 16'h0000; ym = 16'h0000; sm = 16'h01FF;
    repeat (3) @(negedge clk_i);
    compare_all("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1 after reset");

    step(4'd4, 8'h00, 16'hBEEF, "R7 narrow acc load");
    step(4'd5, 8'h00, 16'h0012, "R9 load B");
    step(4'd6, 8'h00, 16'hABCD, "R10 narrow X");
    step(4'd7, 8'h00, 16'h9876, "R10 narrow Y");
    step(4'd8, 8'h00, 16'h3344, "R11 emu stack load");
    step(4'd1, 8'hFF, 16'h0000, "R2 clear in emu");
    step(4'd2, 8'h01, 16'h0000, "R3 set carry");
    step(4'd0, 8'hFF, 16'hFFFF, "R12 idle no effect");
    step(4'd3, 8'h00, 16'h0000, "R4 swap to native");
    step(4'd1, 8'h30, 16'h0000, "R2 clear widths native");
    step(4'd4, 8'h00, 16'h1234, "R8 wide acc load");
    step(4'd5, 8'h00, 16'h0077, "R9 load B wide");
    step(4'd6, 8'h00, 16'hC001, "R10 wide X");
    step(4'd7, 8'h00, 16'hD002, "R10 wide Y");
    step(4'd8, 8'h00, 16'h2468, "R11 native stack");
    step(4'd2, 8'h10, 16'h0000, "R6 narrow index clears hi");
    step(4'd2, 8'hC0, 16'h0000, "R3 set high bits");
    step(4'd2, 8'h20, 16'h0000, "R5 narrow acc");
    step(4'd4, 8'h00, 16'h55AA, "R7 narrow acc native");
    step(4'd1, 8'h30, 16'h0000, "R5 wide again");
    step(4'd6, 8'h00, 16'hFEED, "R10 wide X again");
    step(4'd2, 8'h01, 16'h0000, "R3 carry for entry");
    step(4'd3, 8'h00, 16'h0000, "R12 swap into emu");
    step(4'd3, 8'h00, 16'h0000, "R4 swap zero carry");

    for (int i = 0; i < 400; i++) begin
      step(4'($urandom_range(0, 8)), 8'($urandom), 16'($urandom), "R2 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule